// File: doc/BRIEF.md
# Sequential Matrix Multiplier with Column-Banked Storage

This block forms the product C = A × B of two square matrices of signed 18-bit elements. A single multiply-accumulate datapath produces every result element in turn. Each operand matrix, and the result, is held in a bank of synchronous memories with one memory per column. Each memory has one write port and one read port, and its read data appears one cycle after the address. A and B sit in separate banks, so one operand from each can be fetched in the same cycle.

A host writes the operands element by element through the load port. It then presents the active dimension m and pulses start. Only the upper-left m × m region is computed; the rest of the result storage is left as it was. When the last result element has been stored, the block raises done. The host then reads results back through a registered read port. Operand fetches are issued one cycle ahead of use, so each dot product of m products costs m + 1 cycles. The run time depends only on m.

Top module: `matmul_seq`

## Requirements
- R1: While reset is asserted and after it is released, busy and done are both low.
- R2: When ld_en is high at a clock edge, ld_data is written into matrix A (ld_mat = 0) or matrix B (ld_mat = 1) at row ld_row, column ld_col.
- R3: After a run with dimension m, result element (i, j) equals the sum over k < m of A[i][k]·B[k][j]. Operands are two's-complement values. The sum is kept at full width (2·DW + log2(MAX_N) bits) and never wraps.
- R4: A run with dimension m writes only result positions with row < m and column < m. Every other result position keeps its earlier content.
- R5: If start is accepted at clock edge 0, busy is high after edges 0 through m²·(m+1). done rises at edge m²·(m+1) + 1, at the same edge where busy falls.
- R6: An accepted start clears done at that same edge. done then stays high from the end of the run until the next accepted start.
- R7: start is ignored while busy is high. The timing and the results of the current run do not change.
- R8: start with dim = 0 or dim > MAX_N is ignored: busy stays low and done keeps its value.
- R9: rd_data shows result element (rd_row, rd_col) one clock edge after that address is presented.
- R10: The boundary sizes m = 1 and m = MAX_N follow R3 and R5. At m = MAX_N the most negative operands do not overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_en | input | 1 | Write one operand element this cycle |
| ld_mat | input | 1 | Target operand: 0 = A, 1 = B |
| ld_row | input | $clog2(MAX_N) | Row of the element to write |
| ld_col | input | $clog2(MAX_N) | Column of the element to write |
| ld_data | input | DW | Element value, two's complement |
| dim | input | $clog2(MAX_N+1) | Active dimension m, sampled at start |
| start | input | 1 | Begin a multiplication when idle |
| busy | output | 1 | A run is in progress |
| done | output | 1 | The last run has finished writing its results |
| rd_row | input | $clog2(MAX_N) | Result row to read |
| rd_col | input | $clog2(MAX_N) | Result column to read |
| rd_data | output | 2·DW+$clog2(MAX_N) | Result element, registered, two's complement |

## Verification
After the accepted start edge, the bench compares busy and done on every cycle with a counter of its own. done must appear exactly m²·(m+1)+1 edges later and not one cycle sooner or later, for m = 1, 2, 3, 4 and MAX_N. This includes a run that receives a second start part-way through. Result reads are checked one edge after the address is driven, and each is compared with a product the bench computes behaviourally from the values it loaded. Out-of-region positions are read after a smaller run to confirm they keep the earlier results. Ignored starts are followed by several cycles of observation of busy and done.

// File: rtl/mm_pkg.sv
// Shared definitions for the sequential matrix multiplier.
// Assumes nothing beyond a synthesizable SystemVerilog flow.
package mm_pkg;

    // Sequencer phases: idle, issuing operand reads, waiting for the last write.
    typedef enum logic [1:0] {
        MM_IDLE  = 2'd0,
        MM_RUN   = 2'd1,
        MM_DRAIN = 2'd2
    } mm_state_e;

    // Operand selector values on the load port.
    localparam logic MM_SEL_A = 1'b0;
    localparam logic MM_SEL_B = 1'b1;

endpackage

// File: rtl/mm_colmem.sv
// One column of matrix storage: a simple dual-port memory with one write
// port and one synchronous read port (data one cycle after the address).
// Assumes the caller never needs read-during-write bypass.
module mm_colmem #(
    parameter int W     = 18,
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] mem [DEPTH];

    // Write port: store one element.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Read port: registered output, one cycle latency.
    always_ff @(posedge clk) begin
        rdata <= mem[raddr];
    end

endmodule

// File: rtl/mm_seq.sv
// Loop sequencer: walks i (rows), then j (columns), with k inner, and issues
// one operand fetch per cycle. Each (i,j) takes m+1 cycles: m fetches plus one
// idle slot. After the last fetch it waits for the final result write.
// Assumes MAX_N >= 2 and that dim is stable only when start is high.
module mm_seq
    import mm_pkg::*;
#(
    parameter int MAX_N = 32,
    localparam int IW   = $clog2(MAX_N),
    localparam int DIMW = $clog2(MAX_N + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [DIMW-1:0] dim,
    input  logic            fin_wr,
    output logic            busy,
    output logic            done,
    output logic            iss_v,
    output logic [IW-1:0]   iss_row,
    output logic [IW-1:0]   iss_col,
    output logic [IW-1:0]   iss_k,
    output logic            iss_first,
    output logic            iss_last,
    output logic            iss_fin
);

    localparam logic [DIMW-1:0] MAXD = DIMW'(MAX_N);

    mm_state_e       state;
    logic [DIMW-1:0] dim_q;
    logic [IW-1:0]   i_q, j_q;
    logic [DIMW-1:0] k_q;
    logic [DIMW-1:0] i_ext, j_ext, lim;
    logic            dim_ok, i_end, j_end;

    // Index comparisons against the active dimension.
    always_comb begin
        i_ext  = DIMW'(i_q);
        j_ext  = DIMW'(j_q);
        lim    = dim_q - 1'b1;
        i_end  = (i_ext == lim);
        j_end  = (j_ext == lim);
        dim_ok = (dim != '0) && (dim <= MAXD);
    end

    // Phase, loop counters and done flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= MM_IDLE;
            done  <= 1'b0;
            dim_q <= '0;
            i_q   <= '0;
            j_q   <= '0;
            k_q   <= '0;
        end else begin
            case (state)
                MM_IDLE: begin
                    if (start && dim_ok) begin
                        state <= MM_RUN;
                        dim_q <= dim;
                        done  <= 1'b0;
                        i_q   <= '0;
                        j_q   <= '0;
                        k_q   <= '0;
                    end
                end
                MM_RUN: begin
                    if (k_q == dim_q) begin
                        k_q <= '0;
                        if (j_end) begin
                            j_q <= '0;
                            if (i_end) begin
                                i_q   <= '0;
                                state <= MM_DRAIN;
                            end else begin
                                i_q <= i_q + 1'b1;
                            end
                        end else begin
                            j_q <= j_q + 1'b1;
                        end
                    end else begin
                        k_q <= k_q + 1'b1;
                    end
                end
                MM_DRAIN: begin
                    if (fin_wr) begin
                        state <= MM_IDLE;
                        done  <= 1'b1;
                    end
                end
                default: state <= MM_IDLE;
            endcase
        end
    end

    // Fetch request for the current (i,j,k); none in the idle slot k == m.
    always_comb begin
        busy      = (state != MM_IDLE);
        iss_v     = (state == MM_RUN) && (k_q != dim_q);
        iss_row   = i_q;
        iss_col   = j_q;
        iss_k     = k_q[IW-1:0];
        iss_first = (k_q == '0);
        iss_last  = (k_q == lim);
        iss_fin   = i_end && j_end;
    end

    // R4: the loop indices never leave the active region.
    p_index_in_region_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == MM_RUN) |-> (i_ext < dim_q && j_ext < dim_q && k_q <= dim_q));

    // R5: done and busy are never high together.
    p_done_excludes_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R8: a start with an out-of-range dimension leaves the block idle.
    p_bad_dim_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && !dim_ok) |=> !busy);

    // R7: the active dimension stays fixed for the whole run.
    p_dim_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(dim_q));

endmodule

// File: rtl/mm_mac.sv
// Multiply-accumulate stage: takes one operand pair per valid cycle. The
// accumulator restarts on the first product of a dot product. On the cycle
// after the last product it presents the finished sum as a write request.
// Assumes at least one idle cycle between dot products.
module mm_mac #(
    parameter int DW    = 18,
    parameter int IW    = 5,
    parameter int ACC_W = 41
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    op_v,
    input  logic                    op_first,
    input  logic                    op_last,
    input  logic                    op_fin,
    input  logic [IW-1:0]           op_row,
    input  logic [IW-1:0]           op_col,
    input  logic signed [DW-1:0]    op_a,
    input  logic signed [DW-1:0]    op_b,
    output logic                    wr_en,
    output logic [IW-1:0]           wr_row,
    output logic [IW-1:0]           wr_col,
    output logic signed [ACC_W-1:0] wr_data,
    output logic                    wr_fin
);

    logic signed [2*DW-1:0]  prod;
    logic signed [ACC_W-1:0] acc_q, acc_nx;
    logic                    pend_q;

    // Full-width signed product and next accumulator value.
    always_comb begin
        prod   = op_a * op_b;
        acc_nx = (op_first ? '0 : acc_q) + ACC_W'(prod);
    end

    // Accumulate and latch the destination of a finished dot product.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= '0;
            pend_q <= 1'b0;
            wr_row <= '0;
            wr_col <= '0;
            wr_fin <= 1'b0;
        end else begin
            pend_q <= op_v && op_last;
            if (op_v) acc_q <= acc_nx;
            if (op_v && op_last) begin
                wr_row <= op_row;
                wr_col <= op_col;
                wr_fin <= op_fin;
            end
        end
    end

    // Write request toward the result bank.
    always_comb begin
        wr_en   = pend_q;
        wr_data = acc_q;
    end

    // R4: each result element is written in a single cycle.
    p_single_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    // R5: operands of one dot product arrive on back-to-back cycles.
    p_contiguous_ops_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_v && !op_first) |-> $past(op_v));

endmodule

// File: rtl/matmul_seq.sv
// Top level: banks of column memories for A, B and the result. A single
// sequencer and one multiply-accumulate stage sit between them. A is read from
// column k at row i, and B from column j at row k. Each finished sum goes to
// result column j at row i. The host writes operands only while idle.
module matmul_seq
    import mm_pkg::*;
#(
    parameter int MAX_N  = 32,
    parameter int DW     = 18,
    localparam int IW    = $clog2(MAX_N),
    localparam int DIMW  = $clog2(MAX_N + 1),
    localparam int ACC_W = 2 * DW + IW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_en,
    input  logic             ld_mat,
    input  logic [IW-1:0]    ld_row,
    input  logic [IW-1:0]    ld_col,
    input  logic [DW-1:0]    ld_data,
    input  logic [DIMW-1:0]  dim,
    input  logic             start,
    output logic             busy,
    output logic             done,
    input  logic [IW-1:0]    rd_row,
    input  logic [IW-1:0]    rd_col,
    output logic [ACC_W-1:0] rd_data
);

    logic             iss_v, iss_first, iss_last, iss_fin;
    logic [IW-1:0]    iss_row, iss_col, iss_k;
    logic             s1_v, s1_first, s1_last, s1_fin;
    logic [IW-1:0]    s1_row, s1_col, s1_k;
    logic             wr_en, wr_fin;
    logic [IW-1:0]    wr_row, wr_col;
    logic [ACC_W-1:0] wr_data;
    logic [IW-1:0]    rd_col_q;
    logic [DW-1:0]    a_q [MAX_N];
    logic [DW-1:0]    b_q [MAX_N];
    logic [ACC_W-1:0] r_q [MAX_N];

    mm_seq #(.MAX_N(MAX_N)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .dim(dim),
        .fin_wr(wr_en && wr_fin), .busy(busy), .done(done),
        .iss_v(iss_v), .iss_row(iss_row), .iss_col(iss_col), .iss_k(iss_k),
        .iss_first(iss_first), .iss_last(iss_last), .iss_fin(iss_fin)
    );

    // Column banks: A read at row i, B read at row k, result written at row i.
    for (genvar c = 0; c < MAX_N; c++) begin : g_col
        mm_colmem #(.W(DW), .DEPTH(MAX_N)) u_a (
            .clk(clk), .we(ld_en && ld_mat == MM_SEL_A && ld_col == IW'(c)),
            .waddr(ld_row), .wdata(ld_data), .raddr(iss_row), .rdata(a_q[c])
        );
        mm_colmem #(.W(DW), .DEPTH(MAX_N)) u_b (
            .clk(clk), .we(ld_en && ld_mat == MM_SEL_B && ld_col == IW'(c)),
            .waddr(ld_row), .wdata(ld_data), .raddr(iss_k), .rdata(b_q[c])
        );
        mm_colmem #(.W(ACC_W), .DEPTH(MAX_N)) u_r (
            .clk(clk), .we(wr_en && wr_col == IW'(c)),
            .waddr(wr_row), .wdata(wr_data), .raddr(rd_row), .rdata(r_q[c])
        );
    end

    // Carry fetch tags alongside the one-cycle memory latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_v     <= 1'b0;
            s1_first <= 1'b0;
            s1_last  <= 1'b0;
            s1_fin   <= 1'b0;
            s1_row   <= '0;
            s1_col   <= '0;
            s1_k     <= '0;
            rd_col_q <= '0;
        end else begin
            s1_v     <= iss_v;
            s1_first <= iss_first;
            s1_last  <= iss_last;
            s1_fin   <= iss_fin;
            s1_row   <= iss_row;
            s1_col   <= iss_col;
            s1_k     <= iss_k;
            rd_col_q <= rd_col;
        end
    end

    mm_mac #(.DW(DW), .IW(IW), .ACC_W(ACC_W)) u_mac (
        .clk(clk), .rst_n(rst_n), .op_v(s1_v), .op_first(s1_first),
        .op_last(s1_last), .op_fin(s1_fin), .op_row(s1_row), .op_col(s1_col),
        .op_a(a_q[s1_k]), .op_b(b_q[s1_col]),
        .wr_en(wr_en), .wr_row(wr_row), .wr_col(wr_col), .wr_data(wr_data),
        .wr_fin(wr_fin)
    );

    // Host result read: column chosen one cycle after the address.
    always_comb rd_data = r_q[rd_col_q];

    // R4: results are written only while a run is active.
    p_write_in_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> busy);

    // R3: operands reach the accumulator only during a run.
    p_ops_in_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
        s1_v |-> busy);

endmodule

// File: tb/sim_matmul_seq.sv
module sim_matmul_seq;
    localparam int N    = 32;
    localparam int DW   = 18;
    localparam int IW   = $clog2(N);
    localparam int DIMW = $clog2(N + 1);
    localparam int AW   = 2 * DW + IW;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            ld_en = 1'b0, ld_mat = 1'b0;
    logic [IW-1:0]   ld_row = '0, ld_col = '0;
    logic [DW-1:0]   ld_data = '0;
    logic [DIMW-1:0] dim = '0;
    logic            start = 1'b0;
    logic            busy, done;
    logic [IW-1:0]   rd_row = '0, rd_col = '0;
    logic [AW-1:0]   rd_data;

    longint ra [N][N];
    longint rb [N][N];
    longint rr [N][N];
    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    matmul_seq #(.MAX_N(N), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_mat(ld_mat),
        .ld_row(ld_row), .ld_col(ld_col), .ld_data(ld_data), .dim(dim),
        .start(start), .busy(busy), .done(done),
        .rd_row(rd_row), .rd_col(rd_col), .rd_data(rd_data)
    );

    task automatic check(string req, string what, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // R2: one element per cycle through the load port.
    task automatic load(bit m, int r, int c, longint v);
        @(negedge clk);
        ld_en = 1'b1; ld_mat = m; ld_row = IW'(r); ld_col = IW'(c); ld_data = DW'(v);
        if (m) rb[r][c] = v; else ra[r][c] = v;
    endtask

    task automatic load_end();
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    function automatic longint pat(int seed, int r, int c);
        return longint'(((r * 7 + c * 13 + seed * 5) % 61) - 30);
    endfunction

    task automatic fill(int m, int seed);
        for (int r = 0; r < m; r++)
            for (int c = 0; c < m; c++) begin
                load(1'b0, r, c, pat(seed, r, c));
                load(1'b1, r, c, pat(seed + 3, c, r));
            end
        load_end();
    endtask

    task automatic compute(int m);
        for (int i = 0; i < m; i++)
            for (int j = 0; j < m; j++) begin
                longint s = 0;
                for (int k = 0; k < m; k++) s += ra[i][k] * rb[k][j];
                rr[i][j] = s;
            end
    endtask

    // R5/R6/R7: per-cycle comparison of busy and done against the cycle model.
    task automatic run(int m, int again);
        int tot = m * m * (m + 1);
        @(negedge clk);
        start = 1'b1; dim = DIMW'(m);
        @(negedge clk);
        start = 1'b0;
        check("R6", "done cleared at start", longint'(done), 0);
        check("R5", "busy at start", longint'(busy), 1);
        for (int c = 1; c <= tot + 1; c++) begin
            @(negedge clk);
            check(again != 0 ? "R7" : "R5", "busy", longint'(busy), (c < tot + 1) ? 1 : 0);
            check(again != 0 ? "R7" : "R5", "done", longint'(done), (c >= tot + 1) ? 1 : 0);
            if (again != 0 && c == 3) begin start = 1'b1; dim = DIMW'(again); end
            if (c == 4) start = 1'b0;
        end
        compute(m);
    endtask

    // R9: result is visible one edge after the address.
    task automatic check_one(string req, int i, int j);
        @(negedge clk);
        rd_row = IW'(i); rd_col = IW'(j);
        @(negedge clk);
        check(req, $sformatf("C[%0d][%0d]", i, j), longint'($signed(rd_data)), rr[i][j]);
    endtask

    task automatic check_all(string req, int m);
        for (int i = 0; i < m; i++)
            for (int j = 0; j < m; j++) check_one(req, i, j);
    endtask

    task automatic bad_start(int d);
        logic was_done = done;
        @(negedge clk);
        start = 1'b1; dim = DIMW'(d);
        @(negedge clk);
        start = 1'b0;
        for (int c = 0; c < 3; c++) begin
            check("R8", "busy after bad dim", longint'(busy), 0);
            check("R8", "done after bad dim", longint'(done), longint'(was_done));
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", "busy in reset", longint'(busy), 0);
        check("R1", "done in reset", longint'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "busy after reset", longint'(busy), 0);
        check("R1", "done after reset", longint'(done), 0);

        // Small mixed-sign product (R2, R3, R9).
        fill(4, 1);
        run(4, 0);
        check_all("R3", 4);

        // Full size with extreme operands (R10): A all most-negative, B alternating.
        for (int r = 0; r < N; r++)
            for (int c = 0; c < N; c++) begin
                load(1'b0, r, c, -131072);
                load(1'b1, r, c, (c % 2 == 0) ? -131072 : 131071);
            end
        load_end();
        run(N, 0);
        check_all("R10", N);

        // Smaller run leaves outside positions untouched (R4).
        fill(2, 7);
        run(2, 0);
        check_all("R3", 2);
        check_one("R4", 2, 2);
        check_one("R4", 0, 2);
        check_one("R4", 2, 0);
        check_one("R4", N - 1, N - 1);

        // Minimum dimension (R10).
        load(1'b0, 0, 0, -5);
        load(1'b1, 0, 0, 7);
        load_end();
        run(1, 0);
        check_one("R10", 0, 0);

        // Start while running is ignored (R7).
        fill(3, 11);
        run(3, 1);
        check_all("R7", 3);
        check_one("R4", 3, 3);

        // Out-of-range dimensions are ignored (R8).
        bad_start(0);
        bad_start(N + 1);
        check_one("R8", 0, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule